// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog that software must service periodically. A 32-bit down-counter runs on a core clock and is loaded from a programmed timeout. In two-phase mode, the first time the count runs out the block raises an interrupt and reloads the counter. If the interrupt is still pending when the count runs out a second time, the block raises a reset request, provided that resets are enabled. In single-phase mode, the first expiry goes straight to the reset request and no interrupt is raised.

Software reaches the block over an APB-style bus in its own clock domain. It writes the timeout, the control bits and an interrupt clear. It reads back a snapshot of the live count and of the output state. Commands travel to the core domain through a toggle handshake with two-flop synchronizers. The status snapshot travels back to the bus domain the same way. Each domain has its own clock and its own active-low reset.

Top module: `wdt_dual_stage`

## Requirements
- R1: While the enable bit (bit 0 of the control register at offset 0x04) is 0, the counter holds its value and neither `wdt_irq` nor `wdt_rst` asserts.
- R2: In two-phase mode (control bit 2 = 0), the first expiry asserts `wdt_irq`, leaves `wdt_rst` low and reloads the counter from the timeout register (offset 0x00).
- R3: In two-phase mode with resets enabled (control bit 1 = 1), if the interrupt is still pending at the next expiry, `wdt_rst` rises exactly L+1 core cycles after `wdt_irq` rose, where L is the timeout value.
- R4: With control bit 1 = 0, `wdt_rst` never asserts. The interrupt stays pending across later expiries.
- R5: In single-phase mode (control bit 2 = 1), an expiry asserts `wdt_rst` directly, provided resets are enabled, and `wdt_irq` never asserts.
- R6: Writing 1 to bit 0 of the clear register (offset 0x08) while the interrupt is pending does three things: it drops `wdt_irq`, cancels the coming reset, and reloads the counter. The next interrupt then rises exactly L+1 core cycles later.
- R7: Writing the timeout register while the block is enabled restarts the count from the new value. Regular rewrites keep `wdt_irq` from ever asserting.
- R8: Once asserted, `wdt_rst` stays high, whatever bus writes follow, until the core reset is applied.
- R9: Offset 0x0C reads the current count, which falls while the block runs. Offset 0x10 reads bit 0 = interrupt pending and bit 1 = reset asserted.
- R10: After reset, both outputs are low, the timeout register reads the parameter `RESET_LOAD`, and the control register reads 0.
- R11: Writes issued back to back while a command crossing is still in flight all take effect, and the last written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| cclk | input | 1 | Core counting clock |
| cresetn | input | 1 | Core-domain reset, active low |
| wdt_irq | output | 1 | Interrupt, high while the first-phase timeout is pending |
| wdt_rst | output | 1 | Reset request, held until core reset |

## Verification
Results inside the core domain have exact cycle counts. The interrupt-to-reset gap and the clear-to-next-interrupt gap are both L+1 core cycles. The bench counts them edge by edge on the falling edge of the core clock and compares the exact number. Results that cross a clock domain are not fixed in time. A written command takes effect about four to six core cycles after the bus write. A status snapshot reaches the readable registers a few bus cycles later. The bench therefore polls those results against bounded windows, or waits a fixed margin of 20 to 40 cycles before it reads status back.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int CNT_W = 32;

  typedef struct packed {
    logic [CNT_W-1:0] load;
    logic             en;
    logic             rst_en;
    logic             single;
    logic             kick;
    logic             clr;
  } wdt2_cmd_t;

  typedef struct packed {
    logic             rst;
    logic             irq;
    logic [CNT_W-1:0] count;
  } wdt2_stat_t;

  localparam int CMD_W  = $bits(wdt2_cmd_t);
  localparam int STAT_W = $bits(wdt2_stat_t);

  function automatic logic [CNT_W-1:0] wdt2_dec(input logic [CNT_W-1:0] v);
    return v - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic wdt2_is_zero(input logic [CNT_W-1:0] v);
    return v == '0;
  endfunction
endpackage

// File: rtl/wdt2_xfer.sv
module wdt2_xfer #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         launch,
  input  logic [W-1:0] src_data,
  output logic         busy,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic         dst_valid,
  output logic [W-1:0] dst_data
);
  logic         req_t, ack_s1, ack_s2;
  logic [W-1:0] hold_q;
  logic         req_s1, req_s2, req_s3;
  logic         edge_w;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) begin
      req_t  <= 1'b0;
      hold_q <= '0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= req_s3;
      ack_s2 <= ack_s1;
      if (launch) begin
        req_t  <= ~req_t;
        hold_q <= src_data;
      end
    end
  end

  assign busy   = req_t ^ ack_s2;
  assign edge_w = req_s2 ^ req_s3;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      req_s1    <= 1'b0;
      req_s2    <= 1'b0;
      req_s3    <= 1'b0;
      dst_valid <= 1'b0;
      dst_data  <= '0;
    end else begin
      req_s1    <= req_t;
      req_s2    <= req_s1;
      req_s3    <= req_s2;
      dst_valid <= edge_w;
      if (edge_w) dst_data <= hold_q;
    end
  end

  // R11: a new word is never launched over one still in flight
  p_launch_idle_r11: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    launch |-> !busy);
  // R11: each crossing is delivered as a single pulse
  p_valid_single_r11: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dst_valid |=> !dst_valid);
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int               ADDR_W     = 5,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              cmd_launch,
  output wdt2_cmd_t         cmd,
  input  logic              cmd_busy,
  input  logic              stat_valid,
  input  wdt2_stat_t        stat
);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(5'h10);

  logic [CNT_W-1:0] load_q;
  logic [2:0]       ctrl_q;
  logic             kick_p, clr_p, dirty_q;
  wdt2_stat_t       stat_q;
  logic             wr_w, wr_load, wr_ctrl, wr_clr;

  assign wr_w    = psel && penable && pwrite;
  assign wr_load = wr_w && paddr == A_LOAD;
  assign wr_ctrl = wr_w && paddr == A_CTRL;
  assign wr_clr  = wr_w && paddr == A_CLR && pwdata[0];

  assign cmd_launch = dirty_q && !cmd_busy;
  assign cmd = '{load: load_q, en: ctrl_q[0], rst_en: ctrl_q[1],
                 single: ctrl_q[2], kick: kick_p, clr: clr_p};

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      load_q  <= RESET_LOAD;
      ctrl_q  <= '0;
      kick_p  <= 1'b0;
      clr_p   <= 1'b0;
      dirty_q <= 1'b0;
      stat_q  <= '0;
    end else begin
      if (wr_load) load_q <= pwdata[CNT_W-1:0];
      if (wr_ctrl) ctrl_q <= pwdata[2:0];
      kick_p  <= (kick_p && !cmd_launch) || wr_load;
      clr_p   <= (clr_p && !cmd_launch) || wr_clr;
      dirty_q <= (dirty_q && !cmd_launch) || wr_load || wr_ctrl || wr_clr;
      if (stat_valid) stat_q <= stat;
    end
  end

  always_comb begin
    prdata = '0;
    case (paddr)
      A_LOAD:  prdata = load_q;
      A_CTRL:  prdata = {29'd0, ctrl_q};
      A_COUNT: prdata = stat_q.count;
      A_FLAGS: prdata = {30'd0, stat_q.rst, stat_q.irq};
      default: prdata = '0;
    endcase
  end

  // R11: a pending write is never dropped before it is launched
  p_dirty_kept_r11: assert property (@(posedge pclk) disable iff (!presetn)
    (dirty_q && cmd_busy) |=> dirty_q);
endmodule

// File: rtl/wdt2_core.sv
module wdt2_core
  import wdt2_pkg::*;
#(
  parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  wdt2_cmd_t  cmd,
  output wdt2_stat_t stat,
  output logic       irq_o,
  output logic       rst_o
);
  logic [CNT_W-1:0] count_q, load_q;
  logic             en_q, rsten_q, single_q, irq_q, rst_q;
  logic             run_w, expire_w, phase1_w, fire_w;

  assign run_w    = en_q && !rst_q && !cmd_valid;
  assign expire_w = run_w && wdt2_is_zero(count_q);
  assign phase1_w = expire_w && !single_q && !irq_q;
  assign fire_w   = expire_w && rsten_q && (single_q || irq_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= RESET_LOAD;
      load_q   <= RESET_LOAD;
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      single_q <= 1'b0;
      irq_q    <= 1'b0;
      rst_q    <= 1'b0;
    end else if (cmd_valid) begin
      load_q   <= cmd.load;
      en_q     <= cmd.en;
      rsten_q  <= cmd.rst_en;
      single_q <= cmd.single;
      if (!cmd.en || cmd.single || cmd.clr) irq_q <= 1'b0;
      if (cmd.en && (!en_q || cmd.kick || (cmd.clr && irq_q))) count_q <= cmd.load;
    end else if (run_w) begin
      if (expire_w) begin
        count_q <= load_q;
        if (phase1_w) irq_q <= 1'b1;
        if (fire_w)   rst_q <= 1'b1;
      end else begin
        count_q <= wdt2_dec(count_q);
      end
    end
  end

  assign irq_o = irq_q;
  assign rst_o = rst_q;
  assign stat  = '{rst: rst_q, irq: irq_q, count: count_q};

  // R1: a disabled counter with no command holds its value
  p_hold_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cmd_valid) |=> $stable(count_q));
  // R2: an expiry without reset reloads the timeout
  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !fire_w) |=> count_q == $past(load_q));
  // R3: in two-phase mode a reset follows only a pending interrupt
  p_irq_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_q) && !$past(single_q)) |-> $past(irq_q));
  // R4: reset only rises while resets are enabled
  p_rst_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_q) |-> $past(rsten_q));
  // R5: single-phase mode never holds an interrupt
  p_single_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> !irq_q);
  // R8: reset request is sticky until core reset
  p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);
endmodule

// File: rtl/wdt_dual_stage.sv
module wdt_dual_stage
  import wdt2_pkg::*;
#(
  parameter int               ADDR_W     = 5,
  parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              cclk,
  input  logic              cresetn,
  output logic              wdt_irq,
  output logic              wdt_rst
);
  logic       cmd_launch, cmd_busy, cmd_valid;
  wdt2_cmd_t  cmd_src, cmd_dst;
  logic       stat_busy, stat_valid;
  wdt2_stat_t stat_src, stat_dst;

  wdt2_regs #(.ADDR_W(ADDR_W), .RESET_LOAD(RESET_LOAD)) u_regs (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cmd_launch(cmd_launch), .cmd(cmd_src), .cmd_busy(cmd_busy),
    .stat_valid(stat_valid), .stat(stat_dst)
  );

  wdt2_xfer #(.W(CMD_W)) u_cmd_x (
    .src_clk(pclk), .src_rst_n(presetn), .launch(cmd_launch),
    .src_data(cmd_src), .busy(cmd_busy),
    .dst_clk(cclk), .dst_rst_n(cresetn), .dst_valid(cmd_valid),
    .dst_data(cmd_dst)
  );

  wdt2_core #(.RESET_LOAD(RESET_LOAD)) u_core (
    .clk(cclk), .rst_n(cresetn), .cmd_valid(cmd_valid), .cmd(cmd_dst),
    .stat(stat_src), .irq_o(wdt_irq), .rst_o(wdt_rst)
  );

  wdt2_xfer #(.W(STAT_W)) u_stat_x (
    .src_clk(cclk), .src_rst_n(cresetn), .launch(!stat_busy),
    .src_data(stat_src), .busy(stat_busy),
    .dst_clk(pclk), .dst_rst_n(presetn), .dst_valid(stat_valid),
    .dst_data(stat_dst)
  );
endmodule

// File: tb/sim_wdt_dual_stage.sv
module sim_wdt_dual_stage;
  localparam logic [31:0] RL = 32'hFFFF_FFFF;
  logic pclk = 0, cclk = 0, presetn = 0, cresetn = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic wdt_irq, wdt_rst;
  int errors = 0, checks = 0;
  logic irq_seen = 0;

  always #10 pclk = ~pclk;
  initial begin #7; forever #10 cclk = ~cclk; end
  always @(posedge wdt_irq) irq_seen = 1;

  wdt_dual_stage u0 (.pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .cclk(cclk), .cresetn(cresetn), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic do_reset();
    presetn = 0; cresetn = 0;
    repeat (5) @(negedge pclk);
    presetn = 1; cresetn = 1;
    repeat (10) @(negedge pclk);
    irq_seen = 0;
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge cclk);
  endtask

  task automatic wait_irq(input int lim, output bit ok);
    ok = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge cclk);
      if (wdt_irq) begin ok = 1; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk(!wdt_irq && !wdt_rst, "R10 outputs low", {30'd0, wdt_rst, wdt_irq}, 0);
    rd(5'h00, d); chk(d == RL, "R10 timeout reset", d, RL);
    rd(5'h04, d); chk(d == 0, "R10 control reset", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] a, b;
    do_reset();
    wr(5'h00, 20);
    wait_c(100);
    chk(!wdt_irq && !wdt_rst && !irq_seen, "R1 no output when off", {31'd0, irq_seen}, 0);
    rd(5'h0C, a); wait_c(30); rd(5'h0C, b);
    chk(a == b && a == RL, "R1 count holds", b, RL);
  endtask

  task automatic t_two_phase();
    bit ok; int n; logic [31:0] d;
    do_reset();
    wr(5'h00, 40); wr(5'h04, 3);
    wait_irq(300, ok);
    chk(ok, "R2 irq raised", {31'd0, ok}, 1);
    chk(!wdt_rst, "R2 no reset at first expiry", {31'd0, wdt_rst}, 0);
    n = 0;
    while (!wdt_rst && n < 200) begin @(negedge cclk); n++; end
    chk(n == 41, "R3 reset L+1 after irq", n, 41);
    wait_c(30); rd(5'h10, d);
    chk(d == 3, "R9 flags irq and reset", d, 3);
    wr(5'h08, 1); wr(5'h04, 0); wait_c(40);
    chk(wdt_rst, "R8 reset sticky", {31'd0, wdt_rst}, 1);
    do_reset();
    chk(!wdt_rst, "R8 core reset clears", {31'd0, wdt_rst}, 0);
  endtask

  task automatic t_no_reset();
    bit ok; logic [31:0] d;
    do_reset();
    wr(5'h00, 20); wr(5'h04, 1);
    wait_irq(200, ok);
    wait_c(200);
    chk(!wdt_rst, "R4 reset stays low", {31'd0, wdt_rst}, 0);
    chk(wdt_irq, "R4 irq stays pending", {31'd0, wdt_irq}, 1);
    rd(5'h10, d); chk(d == 1, "R9 flags irq only", d, 1);
  endtask

  task automatic t_single();
    int n;
    do_reset();
    wr(5'h00, 30); wr(5'h04, 7);
    n = 0;
    while (!wdt_rst && n < 300) begin @(negedge cclk); n++; end
    chk(wdt_rst, "R5 reset on first expiry", {31'd0, wdt_rst}, 1);
    chk(!irq_seen, "R5 no irq in single mode", {31'd0, irq_seen}, 0);
  endtask

  task automatic t_clear_cancel();
    bit ok; int n;
    do_reset();
    wr(5'h00, 60); wr(5'h04, 3);
    wait_irq(300, ok);
    wait_c(20); wr(5'h08, 1);
    n = 0;
    while (wdt_irq && n < 40) begin @(negedge cclk); n++; end
    chk(!wdt_irq, "R6 clear drops irq", {31'd0, wdt_irq}, 0);
    n = 0;
    while (!wdt_irq && n < 300) begin @(negedge cclk); n++; end
    chk(n == 61, "R6 fresh phase L+1", n, 61);
    chk(!wdt_rst, "R6 reset cancelled", {31'd0, wdt_rst}, 0);
  endtask

  task automatic t_kick();
    do_reset();
    wr(5'h00, 50); wr(5'h04, 3);
    for (int i = 0; i < 10; i++) begin
      wait_c(30); wr(5'h00, 50);
    end
    chk(!irq_seen && !wdt_rst, "R7 kicks prevent expiry", {31'd0, irq_seen}, 0);
  endtask

  task automatic t_status();
    logic [31:0] a, b;
    do_reset();
    wr(5'h00, 5000); wr(5'h04, 3);
    wait_c(30); rd(5'h0C, a); wait_c(50); rd(5'h0C, b);
    chk(a <= 5000 && b < a, "R9 count falls", b, a);
  endtask

  task automatic t_merge();
    bit ok; logic [31:0] d;
    do_reset();
    wr(5'h00, 1000); wr(5'h00, 25); wr(5'h04, 3);
    rd(5'h00, d); chk(d == 25, "R11 last timeout kept", d, 25);
    wait_irq(100, ok);
    chk(ok, "R11 last write took effect", {31'd0, ok}, 1);
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_two_phase();
    t_no_reset();
    t_single();
    t_clear_cancel();
    t_kick();
    t_status();
    t_merge();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule